// File: doc/BRIEF.md
# Single-Operand Shift and Immediate ALU

This block executes one class of 16-bit instructions that each act on a single register: arithmetic shift right, logical shift left, rotate right, rotate left, add a small immediate, subtract a small immediate, bitwise complement and twos-complement negate. Each word carries a seven-bit opcode, a three-bit field and a destination register address. The block reads the addressed entry of its internal register file, computes the result, writes it back and updates the zero, carry and sign flags. All of this happens in the same cycle in which the word is accepted.

The instruction input uses a valid/ready pair. Ready is always high because every instruction takes one cycle. A combinational read port lets the surrounding logic, or a bench, look at any register. Words that do not belong to this class raise a one-cycle illegal pulse and leave all state untouched.

Top module: `sop_alu`

## Requirements
- R1: A synchronous reset clears every register to 0x0000 and clears the Z, C and S flags and the illegal pulse.
- R2: The opcode is word bits [15:9], the three-bit field is bits [8:6] and the destination address is bits [2:0]. Bits [5:3] are ignored. For shifts, rotates and immediates the count or operand equals field+1, giving a range of 1 to 8.
- R3: Opcode 1101000 shifts the destination right arithmetically, filling the vacated bits with the sign bit. C takes the last bit moved out of bit 0.
- R4: Opcode 1101001 shifts left and fills with zeros. C takes the last bit moved out of bit 15.
- R5: Opcode 1101010 rotates right and opcode 1101011 rotates left. Bits leaving one end re-enter at the other. C takes the last bit moved out, as for the matching shift.
- R6: Opcode 1101100 adds field+1 and opcode 1101101 subtracts field+1, both modulo 2^16. C is left unchanged.
- R7: Opcode 1101111 with field 000 writes the bitwise complement, and with field 001 writes the twos-complement. C is left unchanged.
- R8: After every legal instruction, Z is 1 exactly when the result is 0x0000, and S equals result bit 15.
- R9: Opcode 1101110, opcode 1101111 with a field of 010 to 111, and any opcode outside 1101000 to 1101111 raise `illegal` for exactly one cycle. They change no register and no flag.
- R10: `in_ready` is always 1. An accepted word's register and flag updates are visible after the next rising clock edge. With `in_valid` low, nothing changes.
- R11: `rd_data` shows register `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Instruction word accepted (always 1) |
| in_word | input | 16 | Instruction word |
| rd_addr | input | 3 | Inspection read address |
| rd_data | output | 16 | Inspection read data |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_s | output | 1 | Sign flag |
| illegal | output | 1 | One-cycle pulse after an illegal word was accepted |

## Verification
The assertions check on every cycle that carry holds through the non-shift instructions, that illegal words and idle cycles leave the flags alone, that Z and S track the written value, that writes land in the addressed register, and that rotates preserve the number of ones. Only the bench's scenarios can show the exact shifted and rotated values for each count, the correct carry bit at counts 1 and 8, immediate wrap-around at 0x0000 and 0xFFFF, and the full register file staying intact across long random instruction mixes.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;
   localparam int IW      = 16;
   localparam int OPC_LSB = 9;
   localparam int OPC_W   = 7;
   localparam int FLD_LSB = 6;
   localparam int FLD_W   = 3;
   localparam int AMT_W   = FLD_W + 1;

   localparam logic [OPC_W-1:0] OPC_SHR   = 7'b1101000;
   localparam logic [OPC_W-1:0] OPC_SHL   = 7'b1101001;
   localparam logic [OPC_W-1:0] OPC_ROR   = 7'b1101010;
   localparam logic [OPC_W-1:0] OPC_ROL   = 7'b1101011;
   localparam logic [OPC_W-1:0] OPC_ADDI  = 7'b1101100;
   localparam logic [OPC_W-1:0] OPC_SUBI  = 7'b1101101;
   localparam logic [OPC_W-1:0] OPC_UNARY = 7'b1101111;

   typedef enum logic [2:0] {
      K_SHR, K_SHL, K_ROR, K_ROL, K_ADD, K_SUB, K_NOT, K_NEG
   } kind_e;

   typedef struct packed {
      logic z;
      logic c;
      logic s;
   } flags_t;
endpackage

// File: rtl/sop_decode.sv
`timescale 1ns/1ps
module sop_decode
   import sop_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic [IW-1:0]    word,
   output kind_e            kind,
   output logic             legal,
   output logic             is_shift,
   output logic [AMT_W-1:0] amt,
   output logic [AW-1:0]    dst
);
   logic [OPC_W-1:0] opc;
   logic [FLD_W-1:0] fld;
   logic             unused_hi;

   if (AW < 1 || AW > FLD_LSB) begin : g_bad_aw
      $error("sop_decode: AW must be between 1 and %0d", FLD_LSB);
   end

   assign opc       = word[OPC_LSB +: OPC_W];
   assign fld       = word[FLD_LSB +: FLD_W];
   assign dst       = word[AW-1:0];
   assign amt       = {1'b0, fld} + AMT_W'(1);
   assign unused_hi = ^word[FLD_LSB-1:0];

   always_comb begin
      kind  = K_SHR;
      legal = 1'b1;
      unique case (opc)
         OPC_SHR:  kind = K_SHR;
         OPC_SHL:  kind = K_SHL;
         OPC_ROR:  kind = K_ROR;
         OPC_ROL:  kind = K_ROL;
         OPC_ADDI: kind = K_ADD;
         OPC_SUBI: kind = K_SUB;
         OPC_UNARY: begin
            if (fld == 3'b000)      kind = K_NOT;
            else if (fld == 3'b001) kind = K_NEG;
            else                    legal = 1'b0;
         end
         default: legal = 1'b0;
      endcase
   end

   assign is_shift = legal && (kind inside {K_SHR, K_SHL, K_ROR, K_ROL});
endmodule

// File: rtl/sop_shifter.sv
`timescale 1ns/1ps
module sop_shifter
   import sop_pkg::*;
#(
   parameter int DW      = 16,
   parameter bit USE_LOG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             chk_en,
   input  logic [DW-1:0]    din,
   input  logic [AMT_W-1:0] amt,
   input  logic             right,
   input  logic             rotate,
   output logic [DW-1:0]    dout,
   output logic             cout
);
   localparam int IXW = $clog2(DW);

   if (DW <= (1 << FLD_W)) begin : g_bad_dw
      $error("sop_shifter: DW must exceed the largest count %0d", 1 << FLD_W);
   end

   logic [IXW-1:0] idx_r, idx_l;
   assign idx_r = IXW'(amt - AMT_W'(1));
   assign idx_l = IXW'(DW - int'(amt));
   assign cout  = right ? din[idx_r] : din[idx_l];

   if (USE_LOG) begin : g_log
      logic [DW-1:0] stg [0:AMT_W];
      assign stg[0] = din;
      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
         localparam int S = 1 << k;
         logic [DW-1:0] r_v, l_v;
         assign r_v = rotate ? {stg[k][S-1:0], stg[k][DW-1:S]}
                             : {{S{stg[k][DW-1]}}, stg[k][DW-1:S]};
         assign l_v = rotate ? {stg[k][DW-1-S:0], stg[k][DW-1:DW-S]}
                             : {stg[k][DW-1-S:0], {S{1'b0}}};
         assign stg[k+1] = amt[k] ? (right ? r_v : l_v) : stg[k];
      end
      assign dout = stg[AMT_W];
   end else begin : g_direct
      logic [DW-1:0] sra_v, shl_v, ror_v, rol_v;
      assign sra_v = DW'($signed(din) >>> amt);
      assign shl_v = din << amt;
      assign ror_v = (din >> amt) | (din << (DW - int'(amt)));
      assign rol_v = (din << amt) | (din >> (DW - int'(amt)));
      assign dout  = right ? (rotate ? ror_v : sra_v)
                           : (rotate ? rol_v : shl_v);
   end

   // R5: a rotate keeps the population of ones
   p_rot_ones_r5: assert property (@(posedge clk) disable iff (rst)
      (chk_en && rotate) |-> ($countones(dout) == $countones(din)));
   // R3: arithmetic right shift keeps the sign bit
   p_sra_sign_r3: assert property (@(posedge clk) disable iff (rst)
      (chk_en && right && !rotate) |-> (dout[DW-1] == din[DW-1]));
endmodule

// File: rtl/sop_arith.sv
`timescale 1ns/1ps
module sop_arith
   import sop_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0]    din,
   input  kind_e            kind,
   input  logic [AMT_W-1:0] amt,
   output logic [DW-1:0]    dout
);
   logic [DW-1:0] imm;
   assign imm = DW'(amt);

   always_comb begin
      unique case (kind)
         K_ADD:   dout = din + imm;
         K_SUB:   dout = din - imm;
         K_NOT:   dout = ~din;
         K_NEG:   dout = '0 - din;
         default: dout = din;
      endcase
   end
endmodule

// File: rtl/sop_regfile.sv
`timescale 1ns/1ps
module sop_regfile #(
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("sop_regfile: DEPTH must be a power of two");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign op_data = mem[op_addr];
   assign rd_data = mem[rd_addr];

   // R10: a write is visible at its address after the edge
   p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
      we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sop_alu.sv
`timescale 1ns/1ps
module sop_alu
   import sop_pkg::*;
#(
   parameter int DW             = 16,
   parameter int REGS           = 8,
   parameter bit USE_LOG_BARREL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [IW-1:0]           in_word,
   input  logic [$clog2(REGS)-1:0] rd_addr,
   output logic [DW-1:0]           rd_data,
   output logic                    flag_z,
   output logic                    flag_c,
   output logic                    flag_s,
   output logic                    illegal
);
   localparam int AW = $clog2(REGS);

   if (REGS < 2) begin : g_bad_regs
      $error("sop_alu: REGS must be at least 2");
   end

   kind_e            kind;
   logic             legal, is_shift, accept, we;
   logic [AMT_W-1:0] amt;
   logic [AW-1:0]    dst;
   logic [DW-1:0]    op_data, sh_out, ar_out, wr_data;
   logic             sh_c;
   flags_t           flags_q;
   logic             illegal_q;

   assign in_ready = 1'b1;
   assign accept   = in_valid && in_ready;
   assign we       = accept && legal;

   sop_decode #(.AW(AW)) u_dec (
      .word(in_word), .kind(kind), .legal(legal), .is_shift(is_shift),
      .amt(amt), .dst(dst)
   );

   sop_regfile #(.DW(DW), .DEPTH(REGS), .AW(AW)) u_rf (
      .clk(clk), .rst(rst), .we(we), .waddr(dst), .wdata(wr_data),
      .op_addr(dst), .op_data(op_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   sop_shifter #(.DW(DW), .USE_LOG(USE_LOG_BARREL)) u_sh (
      .clk(clk), .rst(rst), .chk_en(we && is_shift), .din(op_data), .amt(amt),
      .right(kind == K_SHR || kind == K_ROR),
      .rotate(kind == K_ROR || kind == K_ROL),
      .dout(sh_out), .cout(sh_c)
   );

   sop_arith #(.DW(DW)) u_ar (
      .din(op_data), .kind(kind), .amt(amt), .dout(ar_out)
   );

   assign wr_data = is_shift ? sh_out : ar_out;

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q   <= '0;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= accept && !legal;
         if (we) begin
            flags_q.z <= (wr_data == '0);
            flags_q.s <= wr_data[DW-1];
            if (is_shift) flags_q.c <= sh_c;
         end
      end
   end

   assign flag_z  = flags_q.z;
   assign flag_c  = flags_q.c;
   assign flag_s  = flags_q.s;
   assign illegal = illegal_q;

   // R6, R7: carry is held by the non-shift instructions
   p_carry_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (we && !is_shift) |=> $stable(flag_c));
   // R9: an illegal word pulses and leaves the flags alone
   p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      (accept && !legal) |=> (illegal && $stable(flags_q)));
   // R9: the pulse lasts one cycle unless another illegal word follows
   p_illegal_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      (illegal && !(accept && !legal)) |=> !illegal);
   // R10: idle cycles change no flag
   p_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(flags_q));
   // R8: Z and S follow the written value
   p_zs_r8: assert property (@(posedge clk) disable iff (rst)
      we |=> ((flag_z == ($past(wr_data) == '0)) && (flag_s == $past(wr_data[DW-1]))));
endmodule

// File: tb/sim_sop_alu.sv
`timescale 1ns/1ps
module sim_sop_alu;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        in_ready;
   logic [15:0] in_word;
   logic [2:0]  rd_addr;
   logic [15:0] rd_data;
   logic        flag_z, flag_c, flag_s, illegal;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [15:0] m_reg [8];
   logic        m_z, m_c, m_s;

   always #10 clk = ~clk;

   sop_alu u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .rd_addr(rd_addr), .rd_data(rd_data),
      .flag_z(flag_z), .flag_c(flag_c), .flag_s(flag_s), .illegal(illegal)
   );

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [15:0] w);
      case (w[15:9])
         7'b1101000: return "R3";
         7'b1101001: return "R4";
         7'b1101010, 7'b1101011: return "R5";
         7'b1101100, 7'b1101101: return "R6";
         7'b1101111: return (w[8:6] < 3'd2) ? "R7" : "R9";
         default: return "R9";
      endcase
   endfunction

   // reference model: returns {legal, carry_written, result}
   task automatic model(input logic [15:0] w, output bit ok,
                        output bit wc, output logic [15:0] res, output logic c);
      int          n = int'(w[8:6]) + 1;
      logic [15:0] v = m_reg[w[2:0]];
      ok = 1; wc = 0; c = m_c;
      case (w[15:9])
         7'b1101000: begin wc = 1; for (int i = 0; i < n; i++) begin c = v[0];  v = {v[15], v[15:1]}; end end
         7'b1101001: begin wc = 1; for (int i = 0; i < n; i++) begin c = v[15]; v = {v[14:0], 1'b0}; end end
         7'b1101010: begin wc = 1; for (int i = 0; i < n; i++) begin c = v[0];  v = {v[0], v[15:1]}; end end
         7'b1101011: begin wc = 1; for (int i = 0; i < n; i++) begin c = v[15]; v = {v[14:0], v[15]}; end end
         7'b1101100: v = v + 16'(n);
         7'b1101101: v = v - 16'(n);
         7'b1101111: begin
            if (w[8:6] == 3'd0) v = ~v;
            else if (w[8:6] == 3'd1) v = (~v) + 16'd1;
            else ok = 0;
         end
         default: ok = 0;
      endcase
      res = v;
   endtask

   task automatic issue(input logic [15:0] w);
      bit ok, wc;
      logic [15:0] res;
      logic c;
      string t = tag_of(w);
      model(w, ok, wc, res, c);
      @(negedge clk);
      in_word = w; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (ok) begin
         m_reg[w[2:0]] = res;
         m_c = c;
         m_z = (res == 16'h0);
         m_s = res[15];
      end
      rd_addr = w[2:0];
      #1;
      check(t, "dest reg", rd_data, m_reg[w[2:0]]);
      check(ok ? "R8" : "R9", "Z", 16'(flag_z), 16'(m_z));
      check(ok ? "R8" : "R9", "S", 16'(flag_s), 16'(m_s));
      check(t, "C", 16'(flag_c), 16'(m_c));
      check(ok ? "R10" : "R9", "illegal", 16'(illegal), 16'(!ok));
   endtask

   function automatic logic [15:0] mk(input logic [6:0] op, input logic [2:0] f,
                                      input logic [2:0] d);
      return {op, f, 3'b000, d};
   endfunction

   initial begin
      #(20 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7391));
      rst = 1'b1; in_valid = 1'b0; in_word = '0; rd_addr = '0;
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      m_z = 0; m_c = 0; m_s = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state, R11 read port
      for (int i = 0; i < 8; i++) begin
         rd_addr = 3'(i); #1;
         check("R1", "reset reg", rd_data, 16'h0);
      end
      check("R1", "flags", {13'd0, flag_z, flag_c, flag_s}, 16'h0);
      check("R1", "illegal", 16'(illegal), 16'h0);
      check("R10", "ready", 16'(in_ready), 16'h1);

      // directed corners
      issue(mk(7'b1101111, 3'd0, 3'd1));            // NOT r1 -> FFFF (R7)
      issue(mk(7'b1101000, 3'd7, 3'd1));            // SHR by 8 -> FFFF, C=1 (R3)
      issue(mk(7'b1101100, 3'd7, 3'd2));            // ADDI 8 -> 0008 (R6)
      issue(mk(7'b1101001, 3'd7, 3'd2));            // SHL 8 -> 0800
      issue(mk(7'b1101001, 3'd4, 3'd2));            // SHL 5 -> 0000, C=1, Z=1 (R4, R8)
      issue(mk(7'b1101101, 3'd0, 3'd3));            // SUBI 1 -> FFFF wrap (R6)
      issue(mk(7'b1101111, 3'd1, 3'd3));            // NEG -> 0001 (R7)
      issue(mk(7'b1101010, 3'd0, 3'd3));            // ROR 1 -> 8000, C=1 (R5)
      issue(mk(7'b1101011, 3'd1, 3'd3));            // ROL 2 -> 0002, C=0 (R5)
      issue(mk(7'b1101110, 3'd0, 3'd3));            // illegal opcode (R9)
      issue(mk(7'b1101111, 3'd5, 3'd3));            // illegal sub-op (R9)
      issue({7'b1101100, 3'd2, 3'b101, 3'd4});      // R2: bits [5:3] ignored

      // R10: idle with a live word changes nothing
      @(negedge clk);
      in_word = mk(7'b1101111, 3'd0, 3'd3); in_valid = 1'b0;
      @(negedge clk);
      rd_addr = 3'd3; #1;
      check("R10", "idle reg", rd_data, m_reg[3]);
      check("R10", "idle flags", {13'd0, flag_z, flag_c, flag_s}, {13'd0, m_z, m_c, m_s});

      // constrained random mix
      for (int k = 0; k < 600; k++) begin
         logic [15:0] w;
         int sel = $urandom_range(0, 11);
         w = 16'($urandom);
         case (sel)
            0, 1, 2, 3, 4, 5: w[15:9] = 7'b1101000 | 7'(sel);
            6, 7: begin w[15:9] = 7'b1101111; w[8:6] = 3'($urandom_range(0, 1)); end
            8: w[15:9] = 7'b1101111;
            9: w[15:9] = 7'b1101110;
            10: w[15:9] = 7'b1101100;
            default: ;
         endcase
         issue(w);
      end

      // R11: final sweep of the whole register file
      for (int i = 0; i < 8; i++) begin
         rd_addr = 3'(i); #1;
         check("R11", "final reg", rd_data, m_reg[i]);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule